// File: doc/BRIEF.md
# Serial Flag Offset Loader

This block holds the two threshold offsets that a FIFO's partial flags compare against: one for the almost-empty flag and one for the almost-full flag. Software or a controller fills both offsets through a single serial input, one bit per write-clock edge. An active-low select input and an active-low shift-enable input gate the transfer. The block sits in the write-clock domain next to the FIFO's write port. Its offsets feed the flag comparators, and its valid output tells those comparators when the thresholds can be trusted.

The two offsets form one chain. The almost-empty offset comes first, least significant bit first, and the almost-full offset follows, ending with its most significant bit. A bit counter records the position in the chain, so the transfer may stop for any number of cycles and pick up at the next bit. Incoming bits collect in shadow storage. The live offsets change only on the edge that captures the final bit of the chain. Reset loads a default of 127 into both offsets and marks them valid.

Top module: `sofl_offset_loader`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), both offset outputs read 127, `ofs_valid` is 1, and the next captured bit is bit 0 of the chain.
- R2: A bit is captured on a rising `clk` edge only when `prog_sel_n` and `shift_en_n` are both 0. Chain bit k (k = 0 .. 2*OFS_W-1) is the k-th captured bit. Bits 0 .. OFS_W-1 form `empty_ofs`, least significant first. Bits OFS_W .. 2*OFS_W-1 form `full_ofs`, least significant first.
- R3: While `prog_sel_n` is 0 and `shift_en_n` is 1, no bit is captured, whatever the value of `shift_din`.
- R4: If either gate input is 1, loading pauses. When both are 0 again, loading resumes with the next chain bit, and the completed offsets equal those of an uninterrupted load.
- R5: The edge that captures chain bit 0 drives `ofs_valid` to 0, starting from that edge, even if a previous completion is still waiting to raise it.
- R6: `empty_ofs` and `full_ofs` keep their values on every edge except the one that captures the final chain bit. On that edge, both take their new values together.
- R7: `ofs_valid` is still 0 after the edge that captures the final bit and after the next edge. It becomes 1 after the second edge following the capture edge (VALID_LAT = 2).
- R8: A later complete chain replaces both offsets. After the final bit, the counter wraps, so the next captured bit is bit 0 of a new chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_sel_n | input | 1 | Active-low offset-load select |
| shift_en_n | input | 1 | Active-low serial shift enable |
| shift_din | input | 1 | Serial offset data |
| empty_ofs | output | OFS_W | Live almost-empty offset |
| full_ofs | output | OFS_W | Live almost-full offset |
| ofs_valid | output | 1 | Offsets are complete and usable |

## Verification
The bench builds the block with OFS_W = 13 and VALID_LAT = 2, giving a 26-bit chain. At that length, a full load with pauses, a back-to-back reload and a restart that begins one edge after completion all fit in a few hundred cycles. The 13-bit offsets allow values that exceed 12 bits and values with the top bit set, so a misplaced bit or a wrong split between the two offsets would show up in the outputs. The two-edge latency lets the bench check the valid output cycle by cycle, including a new chain that starts while a completion is still in the pipeline.

// File: rtl/sofl_pkg.sv
// Package: shared constants for the serial flag offset loader.
// Assumes offsets are unsigned and no wider than 31 bits.
package sofl_pkg;
    // Offset value loaded into both registers by reset
    localparam int unsigned SOFL_DEFAULT_OFS = 127;

    // Number of serial bits needed to fill both offsets
    function automatic int unsigned sofl_chain_len(input int unsigned ofs_w);
        return 2 * ofs_w;
    endfunction
endpackage

// File: rtl/sofl_bit_counter.sv
// Module: sofl_bit_counter
// Tracks the position of the next serial bit in the offset chain.
// Advances only on a captured bit and wraps to zero after the last
// position, so loading can pause for any number of cycles.
// Assumes CHAIN_LEN >= 2.
module sofl_bit_counter #(
    parameter int unsigned CHAIN_LEN = 28,
    localparam int unsigned IDX_W = $clog2(CHAIN_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    output logic [IDX_W-1:0] bit_idx,
    output logic             first_bit,
    output logic             last_bit
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAIN_LEN - 1);

    // Flags for the first and last captured bit of a chain
    always_comb begin
        first_bit = capture && (bit_idx == '0);
        last_bit  = capture && (bit_idx == LAST_IDX);
    end

    // Advance on each captured bit, wrap after the final position
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_idx <= '0;
        else if (last_bit)
            bit_idx <= '0;
        else if (capture)
            bit_idx <= bit_idx + 1'b1;
    end

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= LAST_IDX);
    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(bit_idx));
    // R8
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_bit |=> (bit_idx == '0));
endmodule

// File: rtl/sofl_shadow_chain.sv
// Module: sofl_shadow_chain
// Collects serial bits into shadow storage at the position given by
// the bit counter. Copies the full chain, including the bit arriving
// on the same edge, to the live offsets on the final bit.
// Assumes bit_idx < 2*OFS_W.
module sofl_shadow_chain #(
    parameter int unsigned OFS_W   = 14,
    parameter int unsigned DEF_OFS = 127,
    localparam int unsigned CHAIN_LEN = 2 * OFS_W,
    localparam int unsigned IDX_W = $clog2(CHAIN_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             last_bit,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             din,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs
);
    logic [CHAIN_LEN-1:0] shadow;
    logic [CHAIN_LEN-1:0] merged;

    // Chain as it stands once the current bit is included
    always_comb begin
        merged = shadow;
        merged[CHAIN_LEN-1] = din;
    end

    // Store each captured bit at its chain position
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else if (capture)
            shadow[bit_idx] <= din;
    end

    // Move the completed chain into the live offsets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_ofs <= OFS_W'(DEF_OFS);
            full_ofs  <= OFS_W'(DEF_OFS);
        end else if (last_bit) begin
            empty_ofs <= merged[OFS_W-1:0];
            full_ofs  <= merged[CHAIN_LEN-1:OFS_W];
        end
    end

    // R6
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_bit |=> ($stable(empty_ofs) && $stable(full_ofs)));
endmodule

// File: rtl/sofl_valid_pipe.sv
// Module: sofl_valid_pipe
// Raises the valid flag VALID_LAT edges after chain completion and
// drops it at once when a new chain starts. A start also flushes any
// completion still in flight.
// Assumes VALID_LAT >= 1.
module sofl_valid_pipe #(
    parameter int unsigned VALID_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic finish,
    output logic valid
);
    logic [VALID_LAT-1:0] pend;

    // Delay line carrying the completion event
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            pend <= '0;
        end else begin
            pend[0] <= finish;
            for (int k = 1; k < int'(VALID_LAT); k++)
                pend[k] <= pend[k-1];
        end
    end

    // Valid flag: cleared by a new chain, set at the end of the delay
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid <= 1'b1;
        else if (start)
            valid <= 1'b0;
        else if (pend[VALID_LAT-1])
            valid <= 1'b1;
    end

    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(pend[VALID_LAT-1]));
    // R7
    valid_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !valid);
endmodule

// File: rtl/sofl_offset_loader.sv
// Module: sofl_offset_loader (top)
// Serial loader for the almost-empty and almost-full offsets of a FIFO.
// Captures one bit per write-clock edge while both active-low gates
// are low, and publishes the offsets once the whole chain is in.
// Assumes all inputs are synchronous to clk.
module sofl_offset_loader #(
    parameter int unsigned OFS_W     = 14,
    parameter int unsigned VALID_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_sel_n,
    input  logic             shift_en_n,
    input  logic             shift_din,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs,
    output logic             ofs_valid
);
    import sofl_pkg::*;

    localparam int unsigned CHAIN_LEN = sofl_chain_len(OFS_W);
    localparam int unsigned IDX_W     = $clog2(CHAIN_LEN);

    logic             capture;
    logic [IDX_W-1:0] bit_idx;
    logic             first_bit;
    logic             last_bit;

    // A bit is taken only when both gates are active
    always_comb capture = !prog_sel_n && !shift_en_n;

    sofl_bit_counter #(.CHAIN_LEN(CHAIN_LEN)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .bit_idx   (bit_idx),
        .first_bit (first_bit),
        .last_bit  (last_bit)
    );

    sofl_shadow_chain #(.OFS_W(OFS_W), .DEF_OFS(SOFL_DEFAULT_OFS)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .last_bit  (last_bit),
        .bit_idx   (bit_idx),
        .din       (shift_din),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    sofl_valid_pipe #(.VALID_LAT(VALID_LAT)) u_valid (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (first_bit),
        .finish (last_bit),
        .valid  (ofs_valid)
    );

    // R5
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_sel_n && !shift_en_n && first_bit) |=> !ofs_valid);
    // R3
    gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_sel_n || shift_en_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));
endmodule

// File: tb/sofl_offset_loader_test.sv
// Directed bench for sofl_offset_loader: OFS_W = 13, VALID_LAT = 2.
module sofl_offset_loader_test;
    localparam int W  = 13;
    localparam int CL = 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prog_sel_n = 1'b1;
    logic         shift_en_n = 1'b1;
    logic         shift_din = 1'b0;
    logic [W-1:0] empty_ofs;
    logic [W-1:0] full_ofs;
    logic         ofs_valid;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sofl_offset_loader #(.OFS_W(W), .VALID_LAT(2)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_sel_n (prog_sel_n),
        .shift_en_n (shift_en_n),
        .shift_din  (shift_din),
        .empty_ofs  (empty_ofs),
        .full_ofs   (full_ofs),
        .ofs_valid  (ofs_valid)
    );

    // Compare one value and report a mismatch
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive inputs at a falling edge and return at the next falling edge
    task automatic cyc(input logic sel, input logic en, input logic d);
        prog_sel_n = sel;
        shift_en_n = en;
        shift_din  = d;
        @(negedge clk);
    endtask

    // Shift chain bits lo..hi of v without pauses
    task automatic shift_range(input logic [CL-1:0] v, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) cyc(1'b0, 1'b0, v[i]);
    endtask

    // Check the offsets against a chain value
    task automatic chk_ofs(input string tag, input logic [CL-1:0] v);
        chk({tag, " empty"}, 32'(empty_ofs), 32'(v[W-1:0]));
        chk({tag, " full"},  32'(full_ofs),  32'(v[CL-1:W]));
    endtask

    // R1: reset state
    task automatic t_reset();
        chk("R1 empty default", 32'(empty_ofs), 32'd127);
        chk("R1 full default", 32'(full_ofs), 32'd127);
        chk("R1 valid", 32'(ofs_valid), 32'd1);
    endtask

    // R2, R5, R6, R7: one uninterrupted load
    task automatic t_plain(input logic [CL-1:0] v, input logic [CL-1:0] prev);
        shift_range(v, 0, 0);
        chk("R5 valid drops on first bit", 32'(ofs_valid), 32'd0);
        shift_range(v, 1, W + 2);
        chk_ofs("R6 live held mid-chain", prev);
        shift_range(v, W + 3, CL - 1);
        chk_ofs("R2 offsets after last bit", v);
        chk("R7 valid low at capture edge", 32'(ofs_valid), 32'd0);
        cyc(1'b1, 1'b1, 1'b0);
        chk("R7 valid low one edge later", 32'(ofs_valid), 32'd0);
        cyc(1'b1, 1'b1, 1'b0);
        chk("R7 valid high two edges later", 32'(ofs_valid), 32'd1);
    endtask

    // R3, R4: load with pauses, junk data during the pauses
    task automatic t_paused(input logic [CL-1:0] v, input logic [CL-1:0] prev);
        shift_range(v, 0, 4);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, ~v[5]);
        chk_ofs("R3 shift disabled leaves live", prev);
        chk("R3 valid stays low", 32'(ofs_valid), 32'd0);
        shift_range(v, 5, 14);
        for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, ~v[15]);
        cyc(1'b1, 1'b1, ~v[15]);
        shift_range(v, 15, CL - 2);
        cyc(1'b0, 1'b1, ~v[CL-1]);
        chk_ofs("R4 paused before final bit", prev);
        shift_range(v, CL - 1, CL - 1);
        chk_ofs("R4 resumed load result", v);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        chk("R4 valid after resumed load", 32'(ofs_valid), 32'd1);
    endtask

    // R5, R8: a new chain starts one edge after completion
    task automatic t_back_to_back(input logic [CL-1:0] a, input logic [CL-1:0] b);
        shift_range(a, 0, CL - 1);
        chk_ofs("R8 first chain", a);
        shift_range(b, 0, 2);
        chk("R5 restart flushes pending valid", 32'(ofs_valid), 32'd0);
        chk_ofs("R8 live kept during restart", a);
        shift_range(b, 3, CL - 1);
        chk_ofs("R8 reload from bit 0 after wrap", b);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        chk("R8 valid after reload", 32'(ofs_valid), 32'd1);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [CL-1:0] va;
        logic [CL-1:0] vb;
        logic [CL-1:0] vc;
        logic [CL-1:0] vd;
        logic [CL-1:0] vdef;
        va   = {13'd4100, 13'd45};
        vb   = {13'd1, 13'd8191};
        vc   = {13'd6553, 13'd2730};
        vd   = {13'd300, 13'd4097};
        vdef = {13'd127, 13'd127};
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain(va, vdef);
        t_paused(vb, va);
        t_back_to_back(vc, vd);
        cyc(1'b1, 1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule